// File: doc/BRIEF.md
# Power stage fault supervisor

This block makes the digital protection decisions for an output stage built from four half-bridges. It takes the per-half-bridge overload and bootstrap-undervoltage flags, the supply-undervoltage flags, three temperature comparator flags (warning low, warning high, critical), the output configuration, an active-low amplifier reset input and a millisecond tick. From these it produces one enable per half-bridge (low means Hi-Z) and three active-low status lines: shutdown, low temperature warning and high temperature warning.

Each fault class has its own recovery rule. A critical temperature latches until the amplifier reset is asserted. An overload latches until the amplifier reset rises, and that rising edge only counts once a guard time has passed since the fault. Supply undervoltage clears by itself. The configuration decides how far an overload spreads: to a bridge pair, to the whole stage, or to the faulty half-bridge alone. The half-bridge enables respond in the same cycle that a flag is seen. The status lines are registered.

The amplifier reset input and all flags are taken to be synchronous to `clk`. Half-bridge index 0 to 3 corresponds to bridges A to D.

Top module: `power_fault_supervisor`

## Requirements
- R1: `otw1_n` equals the inverse of `temp_warn_lo` and `otw2_n` equals the inverse of `temp_warn_hi`, each as sampled at the previous clock edge.
- R2: While `amp_rst_n` is high, a high `temp_crit` forces all of `hb_en` low in the same cycle and sets a latch. From the next cycle on, `sd_n` is low. Both stay so after `temp_crit` falls, until `amp_rst_n` is driven low.
- R3: Any bit of `sup_uv` high forces all of `hb_en` low in the same cycle and drives `sd_n` low one cycle later. Once every bit is low again, the enables return in the same cycle and `sd_n` rises one cycle later, with no reset needed.
- R4: While `amp_rst_n` is high, an overload flag sets a latch for its half-bridge. The latch is cleared only by a rising edge of `amp_rst_n` (low in one cycle, high in the next) that comes after `GUARD_MS` (default 4) `ms_tick` pulses have been counted since the fault first appeared. The count starts at zero in the cycle after the fault appears. An earlier rising edge has no effect: the affected enables stay low and `sd_n` returns low.
- R5: With `out_mode` = 00 (bridge pairs), an overload in half-bridge 0 or 1 turns off 0 and 1, and an overload in 2 or 3 turns off 2 and 3.
- R6: With `out_mode` = 01 (parallel bridge), and also with the unused code 11, an overload in any half-bridge turns off all four.
- R7: With `out_mode` = 10 (single-ended), an overload turns off only its own half-bridge.
- R8: A bootstrap undervoltage flag turns off only its own half-bridge in every mode, does not latch, and does not pull `sd_n` low.
- R9: While `amp_rst_n` is low, all of `hb_en` are low in the same cycle, and `sd_n` is high from the next cycle on, even if faults are present.
- R10: A fault flag sampled high turns off the enables it affects in that same cycle, with no register delay. An accepted clearing edge turns them back on in that same cycle.
- R11: While `rst_n` is low, `sd_n`, `otw1_n` and `otw2_n` are high, and no fault latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| amp_rst_n | input | 1 | Active-low amplifier reset from the controller |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| out_mode | input | 2 | 00 bridge pairs, 01 parallel bridge, 10 single-ended, 11 treated as 01 |
| ovl_flag | input | N_HB | Overload flag per half-bridge |
| bst_uv | input | N_HB | Bootstrap undervoltage flag per half-bridge |
| sup_uv | input | N_SUP | Supply undervoltage flags |
| temp_warn_lo | input | 1 | Junction above lower warning temperature |
| temp_warn_hi | input | 1 | Junction above upper warning temperature |
| temp_crit | input | 1 | Junction above shutdown temperature |
| hb_en | output | N_HB | Half-bridge enable, low means Hi-Z |
| sd_n | output | 1 | Active-low shutdown status |
| otw1_n | output | 1 | Active-low lower temperature warning |
| otw2_n | output | 1 | Active-low upper temperature warning |

## Verification
The hardest case to reach is the overload clearing edge arriving too early. It needs a latched overload, fewer than `GUARD_MS` ticks, a low pulse on the amplifier reset and then its rising edge, and the overload must still be held after that. Directed sequences build this case with an exact tick count. They then add the missing ticks and show that a second edge is accepted. Long random runs that mix sparse faults, reset pulses, ticks and mode changes are compared every cycle against an expected-value model of the requirements in the bench.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    MODE_BRIDGE   = 2'b00,
    MODE_PARALLEL = 2'b01,
    MODE_SINGLE   = 2'b10,
    MODE_RSVD     = 2'b11
  } out_mode_e;
endpackage

// File: rtl/fsup_scope.sv
module fsup_scope
  import fsup_pkg::*;
#(
  parameter int unsigned N_HB = 4
) (
  input  out_mode_e         mode,
  input  logic [N_HB-1:0]   fault,
  output logic [N_HB-1:0]   kill
);
  localparam int unsigned N_PAIR = N_HB / 2;

  logic [N_PAIR-1:0] pair_hit;

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    assign pair_hit[p] = fault[2*p] | fault[2*p+1];
  end

  always_comb begin
    kill = '0;
    case (mode)
      MODE_BRIDGE: begin
        for (int i = 0; i < N_HB; i++) kill[i] = pair_hit[i/2];
      end
      MODE_SINGLE: kill = fault;
      default:     kill = {N_HB{|fault}};
    endcase
  end
endmodule

// File: rtl/fsup_latch.sv
module fsup_latch #(
  parameter int unsigned N_HB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            amp_rst_n,
  input  logic            temp_crit,
  input  logic [N_HB-1:0] ovl_flag,
  input  logic            uv_any,
  input  logic            clear_ovl,
  output logic            ote_eff,
  output logic [N_HB-1:0] ovl_eff,
  output logic            fault_now
);
  logic            ote_q, ote_d;
  logic [N_HB-1:0] ovl_q, ovl_d;

  always_comb begin
    ote_eff   = ote_q | (temp_crit & amp_rst_n);
    ote_d     = amp_rst_n ? ote_eff : 1'b0;
    ovl_eff   = (clear_ovl ? '0 : ovl_q) | (ovl_flag & {N_HB{amp_rst_n}});
    ovl_d     = ovl_eff;
    fault_now = ote_eff | (|ovl_eff) | uv_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ote_q <= 1'b0;
      ovl_q <= '0;
    end else begin
      ote_q <= ote_d;
      ovl_q <= ovl_d;
    end
  end

  // R2: the critical-temperature latch holds while the amplifier reset stays high
  a_r2_ote_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ote_q && amp_rst_n) |=> ote_q);

  // R4: no overload latch bit drops unless a clearing edge was accepted
  a_r4_ovl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_ovl |=> ((ovl_q & $past(ovl_q)) == $past(ovl_q)));
endmodule

// File: rtl/fsup_guard.sv
module fsup_guard #(
  parameter int unsigned GUARD_MS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic amp_rst_n,
  input  logic ms_tick,
  input  logic fault_now,
  output logic accept
);
  localparam int unsigned CW = $clog2(GUARD_MS + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(GUARD_MS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flt_q;
  logic          rin_q;

  always_comb begin
    cnt_d = cnt_q;
    if (fault_now && !flt_q)
      cnt_d = '0;
    else if (ms_tick && (cnt_q != CNT_FULL))
      cnt_d = cnt_q + 1'b1;
    accept = amp_rst_n && !rin_q && (cnt_q == CNT_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_FULL;
      flt_q <= 1'b0;
      rin_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= fault_now;
      rin_q <= amp_rst_n;
    end
  end

  // R4: the guard count never passes its limit
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R4: the count only restarts or steps by one
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1)));
endmodule

// File: rtl/power_fault_supervisor.sv
module power_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int unsigned N_HB     = 4,
  parameter int unsigned N_SUP    = 2,
  parameter int unsigned GUARD_MS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             amp_rst_n,
  input  logic             ms_tick,
  input  logic [1:0]       out_mode,
  input  logic [N_HB-1:0]  ovl_flag,
  input  logic [N_HB-1:0]  bst_uv,
  input  logic [N_SUP-1:0] sup_uv,
  input  logic             temp_warn_lo,
  input  logic             temp_warn_hi,
  input  logic             temp_crit,
  output logic [N_HB-1:0]  hb_en,
  output logic             sd_n,
  output logic             otw1_n,
  output logic             otw2_n
);
  logic            uv_any;
  logic            clear_ovl;
  logic            ote_eff;
  logic [N_HB-1:0] ovl_eff;
  logic [N_HB-1:0] scope_kill;
  logic            fault_now;
  logic            global_off;
  logic            sd_d, otw1_d, otw2_d;

  assign uv_any = |sup_uv;

  fsup_guard #(.GUARD_MS(GUARD_MS)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .amp_rst_n (amp_rst_n),
    .ms_tick   (ms_tick),
    .fault_now (fault_now),
    .accept    (clear_ovl)
  );

  fsup_latch #(.N_HB(N_HB)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .amp_rst_n (amp_rst_n),
    .temp_crit (temp_crit),
    .ovl_flag  (ovl_flag),
    .uv_any    (uv_any),
    .clear_ovl (clear_ovl),
    .ote_eff   (ote_eff),
    .ovl_eff   (ovl_eff),
    .fault_now (fault_now)
  );

  fsup_scope #(.N_HB(N_HB)) u_scope (
    .mode  (out_mode_e'(out_mode)),
    .fault (ovl_eff),
    .kill  (scope_kill)
  );

  always_comb begin
    global_off = !amp_rst_n || uv_any || ote_eff;
    hb_en      = global_off ? '0 : ~(scope_kill | bst_uv);
    sd_d       = amp_rst_n ? !fault_now : 1'b1;
    otw1_d     = !temp_warn_lo;
    otw2_d     = !temp_warn_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sd_n   <= 1'b1;
      otw1_n <= 1'b1;
      otw2_n <= 1'b1;
    end else begin
      sd_n   <= sd_d;
      otw1_n <= otw1_d;
      otw2_n <= otw2_d;
    end
  end

  // R1: warning lines follow the comparators one cycle later
  a_r1_otw1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (otw1_n == !$past(temp_warn_lo)));
  a_r1_otw2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (otw2_n == !$past(temp_warn_hi)));

  // R2: critical temperature pulls shutdown low
  a_r2_crit_sd: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_crit && amp_rst_n) |=> !sd_n);

  // R3: supply undervoltage turns every half-bridge off
  a_r3_uv_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (|sup_uv) |-> (hb_en == '0));

  // R8: bootstrap undervoltage disables its own half-bridge
  a_r8_bst_own: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_uv & hb_en) == '0);

  // R9: amplifier reset forces Hi-Z and releases shutdown
  a_r9_rst_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_rst_n |-> (hb_en == '0));
  a_r9_sd_high: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_rst_n |=> sd_n);
endmodule

// File: tb/power_fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module power_fault_supervisor_tb_top;
  localparam int GUARD = 4;
  localparam int CLK_NS = 20;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       amp_rst_n;
  logic       ms_tick;
  logic [1:0] out_mode;
  logic [3:0] ovl_flag;
  logic [3:0] bst_uv;
  logic [1:0] sup_uv;
  logic       temp_warn_lo, temp_warn_hi, temp_crit;
  logic [3:0] hb_en;
  logic       sd_n, otw1_n, otw2_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  power_fault_supervisor #(.N_HB(4), .N_SUP(2), .GUARD_MS(GUARD)) dut_i (
    .clk(clk), .rst_n(rst_n), .amp_rst_n(amp_rst_n), .ms_tick(ms_tick),
    .out_mode(out_mode), .ovl_flag(ovl_flag), .bst_uv(bst_uv), .sup_uv(sup_uv),
    .temp_warn_lo(temp_warn_lo), .temp_warn_hi(temp_warn_hi), .temp_crit(temp_crit),
    .hb_en(hb_en), .sd_n(sd_n), .otw1_n(otw1_n), .otw2_n(otw2_n)
  );

  // expected-value model built from the requirements
  logic       m_ote, m_flt, m_rq, m_sd, m_o1, m_o2;
  logic [3:0] m_ovl;
  int         m_cnt;
  logic       e_accept, e_ote, e_fault;
  logic [3:0] e_ovl, e_hb;

  function automatic logic [3:0] spread(input logic [1:0] md, input logic [3:0] v);
    case (md)
      2'b00:   spread = {{2{v[3] | v[2]}}, {2{v[1] | v[0]}}};
      2'b10:   spread = v;
      default: spread = {4{|v}};
    endcase
  endfunction

  always_comb begin
    e_accept = amp_rst_n && !m_rq && (m_cnt == GUARD);
    e_ote    = m_ote | (temp_crit & amp_rst_n);
    e_ovl    = (e_accept ? 4'b0 : m_ovl) | (ovl_flag & {4{amp_rst_n}});
    e_fault  = e_ote | (|e_ovl) | (|sup_uv);
    e_hb     = (!amp_rst_n || (|sup_uv) || e_ote) ? 4'b0 : ~(spread(out_mode, e_ovl) | bst_uv);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ote <= 0; m_ovl <= 0; m_cnt <= GUARD; m_flt <= 0; m_rq <= 1;
      m_sd <= 1; m_o1 <= 1; m_o2 <= 1;
    end else begin
      m_ote <= amp_rst_n ? e_ote : 1'b0;
      m_ovl <= e_ovl;
      if (e_fault && !m_flt) m_cnt <= 0;
      else if (ms_tick && m_cnt != GUARD) m_cnt <= m_cnt + 1;
      m_flt <= e_fault;
      m_rq  <= amp_rst_n;
      m_sd  <= amp_rst_n ? !e_fault : 1'b1;
      m_o1  <= !temp_warn_lo;
      m_o2  <= !temp_warn_hi;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
    #1;
    ms_tick = 1'b0;
  endtask

  task automatic settle();
    #2;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      nxt(); ms_tick = 1'b1;
    end
    nxt();
  endtask

  task automatic clear_all();
    ticks(GUARD + 1);
    amp_rst_n = 1'b0;
    nxt();
    amp_rst_n = 1'b1;
    nxt();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int rlow;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; amp_rst_n = 1; ms_tick = 0; out_mode = 2'b00;
    ovl_flag = 0; bst_uv = 0; sup_uv = 0;
    temp_warn_lo = 0; temp_warn_hi = 0; temp_crit = 0;
    repeat (3) @(negedge clk);
    chk("R11 sd_n in reset", {31'b0, sd_n}, 1);
    chk("R11 otw in reset", {30'b0, otw1_n, otw2_n}, 3);
    rst_n = 1;
    nxt();
    chk("R11 enables after reset", {28'b0, hb_en}, 4'hf);

    // R5 bridge pairs, plus early and accepted clearing edges (R4)
    out_mode = 2'b00; ovl_flag = 4'b0010; settle();
    chk("R5 R10 pair A/B off same cycle", {28'b0, hb_en}, 4'b1100);
    nxt(); ovl_flag = 0; settle();
    chk("R4 overload held", {28'b0, hb_en}, 4'b1100);
    chk("R4 sd_n low", {31'b0, sd_n}, 0);
    ticks(2);
    amp_rst_n = 0; settle();
    chk("R9 reset forces Hi-Z", {28'b0, hb_en}, 4'b0000);
    nxt(); settle();
    chk("R9 sd_n high in reset", {31'b0, sd_n}, 1);
    amp_rst_n = 1; settle();
    chk("R4 early edge ignored", {28'b0, hb_en}, 4'b1100);
    nxt(); settle();
    chk("R4 sd_n low after early edge", {31'b0, sd_n}, 0);
    ticks(2);
    amp_rst_n = 0; nxt();
    amp_rst_n = 1; settle();
    chk("R4 R10 late edge accepted", {28'b0, hb_en}, 4'b1111);
    nxt(); settle();
    chk("R4 sd_n released", {31'b0, sd_n}, 1);

    // R6 parallel, both codes
    out_mode = 2'b01; ovl_flag = 4'b0100; settle();
    chk("R6 parallel all off", {28'b0, hb_en}, 4'b0000);
    nxt(); ovl_flag = 0; clear_all(); settle();
    chk("R6 cleared", {28'b0, hb_en}, 4'b1111);
    out_mode = 2'b11; ovl_flag = 4'b0001; settle();
    chk("R6 code 11 all off", {28'b0, hb_en}, 4'b0000);
    nxt(); ovl_flag = 0; clear_all();

    // R7 single-ended
    out_mode = 2'b10; ovl_flag = 4'b1000; settle();
    chk("R7 single own only", {28'b0, hb_en}, 4'b0111);
    nxt(); ovl_flag = 0; clear_all(); settle();
    chk("R7 cleared", {28'b0, hb_en}, 4'b1111);

    // R8 bootstrap
    out_mode = 2'b00; bst_uv = 4'b0100; settle();
    chk("R8 bootstrap own only", {28'b0, hb_en}, 4'b1011);
    nxt(); settle();
    chk("R8 sd_n unaffected", {31'b0, sd_n}, 1);
    bst_uv = 0; settle();
    chk("R8 not latched", {28'b0, hb_en}, 4'b1111);

    // R3 supply undervoltage
    nxt(); sup_uv = 2'b10; settle();
    chk("R3 uv all off", {28'b0, hb_en}, 4'b0000);
    nxt(); settle();
    chk("R3 sd_n low", {31'b0, sd_n}, 0);
    sup_uv = 0; settle();
    chk("R3 self recovery", {28'b0, hb_en}, 4'b1111);
    nxt(); settle();
    chk("R3 sd_n recovers", {31'b0, sd_n}, 1);

    // R2 critical temperature latch
    temp_crit = 1; settle();
    chk("R2 crit all off", {28'b0, hb_en}, 4'b0000);
    nxt(); temp_crit = 0; settle();
    chk("R2 latched after flag drops", {28'b0, hb_en}, 4'b0000);
    chk("R2 sd_n low", {31'b0, sd_n}, 0);
    ticks(1); settle();
    chk("R2 still latched", {28'b0, hb_en}, 4'b0000);
    amp_rst_n = 0; nxt(); amp_rst_n = 1; settle();
    chk("R2 cleared by reset", {28'b0, hb_en}, 4'b1111);
    nxt(); settle();
    chk("R2 sd_n released", {31'b0, sd_n}, 1);

    // R1 warnings
    temp_warn_lo = 1; nxt(); settle();
    chk("R1 otw1 low otw2 high", {30'b0, otw1_n, otw2_n}, 2'b01);
    temp_warn_hi = 1; nxt(); settle();
    chk("R1 both warnings", {30'b0, otw1_n, otw2_n}, 2'b00);
    temp_warn_lo = 0; temp_warn_hi = 0; nxt(); settle();
    chk("R1 warnings clear", {30'b0, otw1_n, otw2_n}, 2'b11);

    // random phase against the model
    rlow = 0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk); #1;
      for (int i = 0; i < 4; i++) begin
        ovl_flag[i] = ($urandom % 80) == 0;
        bst_uv[i]   = ($urandom % 40) == 0;
      end
      for (int i = 0; i < 2; i++) sup_uv[i] = ($urandom % 90) == 0;
      temp_crit = ($urandom % 300) == 0;
      if (($urandom % 20) == 0) temp_warn_lo = $urandom % 2;
      if (($urandom % 20) == 0) temp_warn_hi = $urandom % 2;
      if (($urandom % 100) == 0) out_mode = 2'($urandom % 4);
      ms_tick = ($urandom % 3) == 0;
      if (rlow > 0) begin amp_rst_n = 0; rlow--; end
      else begin
        amp_rst_n = 1;
        if (($urandom % 25) == 0) rlow = 1 + ($urandom % 3);
      end
      settle();
      chk("R5 R6 R7 R8 R10 random enables", {28'b0, hb_en}, {28'b0, e_hb});
      chk("R2 R3 R4 R9 random sd_n", {31'b0, sd_n}, {31'b0, m_sd});
      chk("R1 random warnings", {30'b0, otw1_n, otw2_n}, {30'b0, m_o1, m_o2});
    end
    finish_run();
  end
endmodule